// File: doc/BRIEF.md
# Sixteen-Pin GPIO Register Bank with Change Interrupt

This block is the register core of a general-purpose I/O expander with two 8-bit ports. A bus front end decodes serial transactions. It then hands this core single-cycle write and read strobes, a 3-bit register index and a data byte. Each port has four registers: direction, output latch, read inversion mask and captured input. The direction register drives the pad output enables. The output latch drives the pad output values. A read of a captured-input register samples the live pins at that moment.

The core also raises an interrupt request as an open-drain enable. The request is set whenever a pin configured as input differs from the value last captured for it. It is cleared when that port is read or when the pin returns to its captured level. Pins are expected to arrive already synchronised to `clk`. The reset input is asserted asynchronously and released through a two-stage synchroniser.

Top module: `gpio_bank_core`

## Requirements
- R1: While the synchronised reset is active, and after its release until the first write: `pin_oe` is all zeros (every pin is an input), `pin_out` is all ones, `irq_n_oe` is 0 and `rd_data` is 0x00. The captured inputs reset to all ones.
- R2: The register index is {kind[1:0], port}. Bit 0 selects port 0 or 1. The kind is 0 for captured input, 1 for output latch, 2 for inversion mask and 3 for direction. This gives indices 0/1 input, 2/3 output, 4/5 inversion and 6/7 direction.
- R3: A direction bit of 1 makes its pin an input (`pin_oe` bit 0). A direction bit of 0 makes it an output (`pin_oe` bit 1). `pin_oe` follows a write on the clock edge that takes the write.
- R4: A write to an output latch appears on that port's `pin_out` bits on the edge that takes the write, whatever the direction setting.
- R5: A read of index 0 or 1 captures that port's live pins on the read edge. `rd_data`, valid from that edge, equals the pins XOR the port's inversion mask.
- R6: Reads of the output, inversion and direction registers return the value last written. Each read returns its data on the edge after `rd_en` is sampled.
- R7: Writes to indices 0 and 1 change nothing: not the pins, not the interrupt, not any captured value.
- R8: `irq_n_oe` goes to 1 on the edge after any input-configured pin differs from its captured value.
- R9: A read of a port's input register drops that port's mismatch on the read edge. `irq_n_oe` falls on that edge if the other port matches. A read of the other port does not clear it.
- R10: A pin that returns to its captured level releases the interrupt on the next edge, with no register read.
- R11: Pins configured as outputs never contribute to the interrupt.
- R12: `rd_data` holds its value on every cycle without `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| reg_idx | input | 3 | Register index {kind, port} |
| wr_data | input | 8 | Write data byte |
| rd_data | output | 8 | Registered read data |
| pin_in | input | 16 | Synchronised pin levels |
| pin_oe | output | 16 | Pad output enable per pin |
| pin_out | output | 16 | Pad output value per pin |
| irq_n_oe | output | 1 | 1 pulls the shared active-low interrupt line low |

## Verification
The bench raises a mismatch on one port and reads the other port first. A design that clears the interrupt globally on any input read would drop the line early. It then restores a pin without any read, which catches a design that only releases on capture. Pins set as outputs are toggled to show they are kept out of the comparison. A write to an input index is issued while a mismatch is pending; a design that latched that write would silence the interrupt. Inverted input readback and the one-cycle read latency are checked with asymmetric masks, so a swapped port or an inverted mask on the wrong register shows up.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [1:0] {
    KIND_IN  = 2'd0,
    KIND_OUT = 2'd1,
    KIND_POL = 2'd2,
    KIND_CFG = 2'd3
  } reg_kind_e;

  localparam int unsigned IDX_W = 3;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_wr,
  input  logic              sel_rd,
  input  reg_kind_e         kind,
  input  logic [PORT_W-1:0] wr_data,
  input  logic [PORT_W-1:0] pin_in,
  output logic [PORT_W-1:0] cfg_o,
  output logic [PORT_W-1:0] out_o,
  output logic [PORT_W-1:0] rdata,
  output logic              mismatch
);
  logic [PORT_W-1:0] cfg_q, cfg_d;
  logic [PORT_W-1:0] out_q, out_d;
  logic [PORT_W-1:0] pol_q, pol_d;
  logic [PORT_W-1:0] cap_q, cap_d;
  logic              cfg_en, out_en, pol_en, cap_en;

  // Clock enables per register; writes to the input kind have no enable.
  always_comb begin
    cfg_en = sel_wr && (kind == KIND_CFG);
    out_en = sel_wr && (kind == KIND_OUT);
    pol_en = sel_wr && (kind == KIND_POL);
    cap_en = sel_rd && (kind == KIND_IN);
    cfg_d  = cfg_en ? wr_data : cfg_q;
    out_d  = out_en ? wr_data : out_q;
    pol_d  = pol_en ? wr_data : pol_q;
    cap_d  = cap_en ? pin_in  : cap_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '1;
      out_q <= '1;
      pol_q <= '0;
      cap_q <= '1;
    end else begin
      cfg_q <= cfg_d;
      out_q <= out_d;
      pol_q <= pol_d;
      cap_q <= cap_d;
    end
  end

  // Read mux: the input kind returns the value being captured this cycle.
  always_comb begin
    unique case (kind)
      KIND_IN:  rdata = pin_in ^ pol_q;
      KIND_OUT: rdata = out_q;
      KIND_POL: rdata = pol_q;
      default:  rdata = cfg_q;
    endcase
  end

  // Compared against the post-edge capture so a read clears on its own edge.
  assign mismatch = |((pin_in ^ cap_d) & cfg_q);
  assign cfg_o    = cfg_q;
  assign out_o    = out_q;
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned NUM_PORTS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PORTS-1:0] port_mismatch,
  output logic                 irq_n_oe
);
  logic irq_q, irq_d;

  always_comb begin
    irq_d = |port_mismatch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_n_oe = irq_q;
endmodule

// File: rtl/gpio_bank_core.sv
module gpio_bank_core
  import gpio_bank_pkg::*;
#(
  parameter int unsigned PORT_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [2:0]            reg_idx,
  input  logic [PORT_W-1:0]     wr_data,
  output logic [PORT_W-1:0]     rd_data,
  input  logic [2*PORT_W-1:0]   pin_in,
  output logic [2*PORT_W-1:0]   pin_oe,
  output logic [2*PORT_W-1:0]   pin_out,
  output logic                  irq_n_oe
);
  localparam int unsigned NUM_PORTS = 2;

  logic                 rst_n_sync;
  reg_kind_e            kind;
  logic [NUM_PORTS-1:0] port_mismatch;
  logic [PORT_W-1:0]    port_rdata [NUM_PORTS];
  logic [PORT_W-1:0]    rd_data_q, rd_data_d;

  assign kind = reg_kind_e'(reg_idx[2:1]);

  gpio_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PORT_W-1:0] cfg_w;
    logic [PORT_W-1:0] out_w;

    gpio_port #(.PORT_W(PORT_W)) u_port (
      .clk      (clk),
      .rst_n    (rst_n_sync),
      .sel_wr   (wr_en && (reg_idx[0] == p[0])),
      .sel_rd   (rd_en && (reg_idx[0] == p[0])),
      .kind     (kind),
      .wr_data  (wr_data),
      .pin_in   (pin_in[p*PORT_W +: PORT_W]),
      .cfg_o    (cfg_w),
      .out_o    (out_w),
      .rdata    (port_rdata[p]),
      .mismatch (port_mismatch[p])
    );

    assign pin_oe [p*PORT_W +: PORT_W] = ~cfg_w;
    assign pin_out[p*PORT_W +: PORT_W] = out_w;
  end

  gpio_irq #(.NUM_PORTS(NUM_PORTS)) u_irq (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .port_mismatch (port_mismatch),
    .irq_n_oe      (irq_n_oe)
  );

  always_comb begin
    rd_data_d = rd_en ? port_rdata[reg_idx[0]] : rd_data_q;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) rd_data_q <= '0;
    else             rd_data_q <= rd_data_d;
  end

  assign rd_data = rd_data_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned PORT_W = 8
) (
  input logic                clk,
  input logic                rst_ni,
  input logic                wr_en,
  input logic                rd_en,
  input logic [2:0]          reg_idx,
  input logic [PORT_W-1:0]   wr_data,
  input logic [PORT_W-1:0]   rd_data,
  input logic [2*PORT_W-1:0] pin_oe,
  input logic [2*PORT_W-1:0] pin_out,
  input logic                irq_n_oe
);
  for (genvar p = 0; p < 2; p++) begin : g_chk
    p_cfg_drives_oe_r3: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_en && reg_idx == {2'd3, p[0]}) |=> pin_oe[p*PORT_W +: PORT_W] == ~$past(wr_data));

    p_latch_drives_out_r4: assert property (@(posedge clk) disable iff (!rst_ni)
      (wr_en && reg_idx == {2'd1, p[0]}) |=> pin_out[p*PORT_W +: PORT_W] == $past(wr_data));
  end

  p_input_write_inert_r7: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && reg_idx[2:1] == 2'd0) |=> ($stable(pin_oe) && $stable(pin_out)));

  p_outputs_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (pin_oe == '1) |=> !irq_n_oe);

  p_rdata_holds_r12: assert property (@(posedge clk) disable iff (!rst_ni)
    !rd_en |=> $stable(rd_data));
endmodule

bind gpio_bank_core gpio_bank_chk #(.PORT_W(PORT_W)) u_chk (
  .clk      (clk),
  .rst_ni   (rst_n_sync),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .reg_idx  (reg_idx),
  .wr_data  (wr_data),
  .rd_data  (rd_data),
  .pin_oe   (pin_oe),
  .pin_out  (pin_out),
  .irq_n_oe (irq_n_oe)
);

// File: tb/sim_gpio_bank_core.sv
`timescale 1ns/1ps
module sim_gpio_bank_core;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [2:0]  reg_idx;
  logic [7:0]  wr_data;
  logic [7:0]  rd_data;
  logic [15:0] pin_in;
  logic [15:0] pin_oe;
  logic [15:0] pin_out;
  logic        irq_n_oe;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  gpio_bank_core #(.PORT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .reg_idx(reg_idx), .wr_data(wr_data), .rd_data(rd_data),
    .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .irq_n_oe(irq_n_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] idx, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; reg_idx = idx; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; reg_idx = idx;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pin_in = v;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 pin_oe", pin_oe, 32'h0000);
    chk("R1 pin_out", pin_out, 32'hFFFF);
    chk("R1 irq", irq_n_oe, 0);
    chk("R1 rd_data", rd_data, 0);
  endtask

  task automatic t_dir();
    logic [7:0] d;
    wr(3'd6, 8'h0F);
    chk("R3 oe port0", pin_oe[7:0], 8'hF0);
    wr(3'd7, 8'hAA);
    chk("R3 oe port1", pin_oe[15:8], 8'h55);
    rd(3'd6, d); chk("R6 R2 cfg0 readback", d, 8'h0F);
    rd(3'd7, d); chk("R6 R2 cfg1 readback", d, 8'hAA);
  endtask

  task automatic t_out();
    logic [7:0] d;
    wr(3'd2, 8'h3C);
    wr(3'd3, 8'hC3);
    chk("R4 pin_out", pin_out, 32'hC33C);
    rd(3'd2, d); chk("R6 out0 readback", d, 8'h3C);
    rd(3'd3, d); chk("R6 out1 readback", d, 8'hC3);
  endtask

  task automatic t_pol();
    logic [7:0] d;
    wr(3'd4, 8'hF0);
    wr(3'd5, 8'h01);
    set_pins(16'h665A);
    rd(3'd0, d); chk("R5 inverted input port0", d, 8'hAA);
    rd(3'd1, d); chk("R5 inverted input port1", d, 8'h67);
    rd(3'd4, d); chk("R6 pol0 readback", d, 8'hF0);
    rd(3'd5, d); chk("R6 pol1 readback", d, 8'h01);
    repeat (3) @(negedge clk);
    chk("R12 rd_data held", rd_data, 8'h01);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d;
    wr(3'd6, 8'hFF);
    wr(3'd7, 8'hFF);
    set_pins(16'h1234);
    rd(3'd0, d); rd(3'd1, d);
    @(negedge clk);
    chk("R9 idle after capture", irq_n_oe, 0);
    set_pins(16'h123C);
    chk("R8 irq raised", irq_n_oe, 1);
    rd(3'd1, d);
    chk("R9 other port read keeps irq", irq_n_oe, 1);
    rd(3'd0, d);
    chk("R9 own port read clears irq", irq_n_oe, 0);
    chk("R5 capture value", d, 8'h3C);
    set_pins(16'h103C);
    chk("R8 irq on port1 bit", irq_n_oe, 1);
    set_pins(16'h123C);
    chk("R10 restore releases irq", irq_n_oe, 0);
  endtask

  task automatic t_outputs_excluded();
    wr(3'd6, 8'h00);
    set_pins(16'h12C3);
    @(negedge clk);
    chk("R11 output pins no irq", irq_n_oe, 0);
    set_pins(16'h123C);
    wr(3'd6, 8'hFF);
    @(negedge clk);
    chk("R11 restored no irq", irq_n_oe, 0);
  endtask

  task automatic t_input_write();
    logic [7:0] d;
    set_pins(16'h1200);
    chk("R8 mismatch before write", irq_n_oe, 1);
    wr(3'd0, 8'h00);
    @(negedge clk);
    chk("R7 input write keeps irq", irq_n_oe, 1);
    chk("R7 input write pin_oe", pin_oe, 32'h0000);
    chk("R7 input write pin_out", pin_out, 32'hC33C);
    set_pins(16'h123C);
    chk("R7 capture unchanged by write", irq_n_oe, 0);
    rd(3'd0, d);
    chk("R5 R2 input read after write", d, 8'h3C);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
    reg_idx = 3'd0; wr_data = 8'h00; pin_in = 16'hFFFF;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_dir();
    t_out();
    t_pol();
    t_irq();
    t_outputs_excluded();
    t_input_write();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule